// File: doc/BRIEF.md
# Display Sync Conditioner

This block sits between the horizontal and vertical sync inputs of a display monitor and the rest of the monitor controller. Both inputs are resynchronised to the system clock and passed on unchanged. Each input is also watched for its polarity and for whether it is present. A polarity bit reports which level is the active one. A missing bit reports that the input has stopped toggling for longer than a timeout.

From the horizontal input the block generates a clamp pulse. The pulse is triggered by either the leading or the trailing edge of the sync pulse, and its length comes from a 2-bit code. A vertical event output gives one pulse per real vertical sync pulse. An internal dummy vertical source can also feed this output at a fixed rate, for use when no real vertical sync is present, and a mute bit can keep the dummy ticks off the event line. A small register bus, read and written on the system clock, gives access to the status and control bits.

Each sync input has a monitor state machine with two states. It starts in `MON_SEEK` (no period reference yet) and takes the transition *first-rise* to `MON_MEASURE` on the first rising edge. It returns through *quiet-timeout* to `MON_SEEK` when no edge arrives within the timeout. The clamp machine starts in `CLP_IDLE` and takes the transition *trigger* to `CLP_PULSE` on the selected edge. It leaves through *expire* back to `CLP_IDLE` when its width count reaches zero.

Top module: `sync_conditioner`

## Requirements
- R1: `h_out` and `v_out` equal `h_in` and `v_in` delayed by exactly two clock edges, with the same polarity.
- R2: Status bit 0 (horizontal polarity) becomes 1 at a rising edge when the completed rising-to-rising period had more high cycles than low cycles. Otherwise it becomes 0, ties included. It reads 0 after reset.
- R3: Status bit 1 (vertical polarity) follows the same rule as R2, applied to `v_in`.
- R4: Status bit 2 (horizontal missing) and status bit 3 (vertical missing) are set after `H_TIMEOUT` or `V_TIMEOUT` clocks pass without an edge on the input. The next edge on that input clears the bit.
- R5: Control bit 0 selects the clamp trigger. At 0 the leading edge starts the clamp, and at 1 the trailing edge starts it. The leading edge is the rising edge when the polarity is positive and the falling edge when it is negative. The clamp output first reads high on the third clock edge after `h_in` changes. The edge that is not selected starts no pulse.
- R6: Control bits 2:1 hold the width code. Codes 0, 1, 2 and 3 give clamp pulses of 8, 16, 32 and 64 clocks.
- R7: Control bit 3 enables the dummy vertical source. The source raises `v_event` for one clock every `CLK_HZ/FRAME_HZ` clocks.
- R8: Control bit 4 set to 1 keeps dummy ticks off `v_event`. Real vertical leading edges still produce an event while it is set.
- R9: Each vertical leading edge produces a one-clock `v_event`, starting on the third clock edge after `v_in` changes. When a leading edge and a dummy tick fall in the same cycle, the result is a single one-clock pulse.
- R10: Address 1 reads back control bits 4:0, with bits 7:5 reading 0. Address 0 reads the status bits, with bits 7:4 reading 0. Both read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_in | input | 1 | Horizontal or composite sync input |
| v_in | input | 1 | Vertical sync input |
| reg_addr | input | 1 | Register select: 0 status, 1 control |
| reg_we | input | 1 | Write strobe for the control register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| h_out | output | 1 | Resynchronised horizontal sync |
| v_out | output | 1 | Resynchronised vertical sync |
| clamp_out | output | 1 | Horizontal clamp pulse |
| v_event | output | 1 | One-clock vertical event |

## Verification
A dummy tick and a real vertical leading edge can arrive in the same cycle, and both drive `v_event`. The bench finds the phase of the dummy source by waiting for one of its events. It then drives the vertical leading edge exactly so that the event the edge produces lands on the next tick. The check is that the window around that cycle holds exactly one event. A second run places the edge away from the tick, and there the bench expects two separate events.

// File: rtl/sync_pkg.sv
package sync_pkg;

    typedef enum logic {
        MON_SEEK,
        MON_MEASURE
    } mon_state_t;

    typedef enum logic {
        CLP_IDLE,
        CLP_PULSE
    } clp_state_t;

    // control register layout, bit 4 down to bit 0
    typedef struct packed {
        logic       dummy_mute;
        logic       dummy_en;
        logic [1:0] width_code;
        logic       trail_sel;
    } ctrl_t;

endpackage

// File: rtl/sync_input.sv
module sync_input (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic s,
    output logic rise,
    output logic fall
);
    logic meta, s_q, prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= 1'b0;
            s_q  <= 1'b0;
            prev <= 1'b0;
        end else begin
            meta <= raw;
            s_q  <= meta;
            prev <= s_q;
        end
    end

    assign s    = s_q;
    assign rise = s_q & ~prev;
    assign fall = ~s_q & prev;
endmodule

// File: rtl/sync_monitor.sv
module sync_monitor #(
    parameter int TIMEOUT = 65536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic s,
    input  logic rise,
    input  logic fall,
    output logic pol,
    output logic missing
);
    import sync_pkg::*;

    localparam int CW = $clog2(TIMEOUT) + 1;
    localparam logic [CW-1:0] TO_LAST = CW'(TIMEOUT - 1);

    mon_state_t    state, state_nx;
    logic [CW-1:0] hi_cnt, lo_cnt, idle_cnt;
    logic          any_edge, quiet_hit;

    assign any_edge  = rise | fall;
    assign quiet_hit = !any_edge && (idle_cnt == TO_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MON_SEEK;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            MON_SEEK:    if (rise)      state_nx = MON_MEASURE;
            MON_MEASURE: if (quiet_hit) state_nx = MON_SEEK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt   <= '0;
            lo_cnt   <= '0;
            idle_cnt <= '0;
            pol      <= 1'b0;
            missing  <= 1'b0;
        end else begin
            if (any_edge)                idle_cnt <= '0;
            else if (idle_cnt != TO_LAST) idle_cnt <= idle_cnt + 1'b1;

            if (any_edge)       missing <= 1'b0;
            else if (quiet_hit) missing <= 1'b1;

            if (rise) begin
                hi_cnt <= CW'(1);
                lo_cnt <= '0;
            end else if (state == MON_MEASURE) begin
                if (s && hi_cnt != '1)       hi_cnt <= hi_cnt + 1'b1;
                else if (!s && lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
            end

            if (rise && state == MON_MEASURE) pol <= (hi_cnt > lo_cnt);
        end
    end

    // R2 / R3: polarity moves only at a rising edge that closes a period
    assert_pol_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && state == MON_MEASURE) |=> $stable(pol));
    // R4: an edge always clears the missing flag
    assert_clear_on_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        any_edge |=> !missing);
    // R4: the flag is raised only in a quiet cycle
    assert_set_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(missing) |-> $past(!any_edge));
endmodule

// File: rtl/clamp_gen.sv
module clamp_gen #(
    parameter int BASE = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lead,
    input  logic       trail,
    input  logic       trail_sel,
    input  logic [1:0] width_code,
    output logic       clamp
);
    import sync_pkg::*;

    localparam int CW = $clog2(BASE * 8);

    clp_state_t  state, state_nx;
    logic [CW-1:0] cnt;
    logic [CW:0]   span;
    logic          trig;

    assign trig = trail_sel ? trail : lead;
    assign span = (CW+1)'(BASE) << width_code;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CLP_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CLP_IDLE:  if (trig)      state_nx = CLP_PULSE;
            CLP_PULSE: if (cnt == '0) state_nx = CLP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt <= '0;
        else if (state == CLP_IDLE && trig) cnt <= CW'(span - 1'b1);
        else if (state == CLP_PULSE)     cnt <= cnt - 1'b1;
    end

    always_comb clamp = (state == CLP_PULSE);

    // R6: the pulse holds while the width count has cycles left
    assert_hold_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CLP_PULSE && cnt != '0) |=> state == CLP_PULSE);
    // R5: a pulse starts only right after a sync edge
    assert_start_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clamp) |-> $past(lead | trail));
endmodule

// File: rtl/dummy_vgen.sv
module dummy_vgen #(
    parameter int PERIOD = 333333
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int DW = $clog2(PERIOD);
    localparam logic [DW-1:0] LAST = DW'(PERIOD - 1);

    logic [DW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (!en)         cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = en && (cnt == LAST);

    // R7: ticks are isolated single cycles
    assert_single_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/sync_conditioner.sv
module sync_conditioner #(
    parameter int CLK_HZ     = 20_000_000,
    parameter int FRAME_HZ   = 60,
    parameter int H_TIMEOUT  = 65536,
    parameter int V_TIMEOUT  = 4194304,
    parameter int CLAMP_BASE = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       h_in,
    input  logic       v_in,
    input  logic       reg_addr,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       h_out,
    output logic       v_out,
    output logic       clamp_out,
    output logic       v_event
);
    import sync_pkg::*;

    localparam int DUMMY_PERIOD = CLK_HZ / FRAME_HZ;

    // channel 0 = horizontal, channel 1 = vertical (R1..R4)
    logic [1:0] raw, s, rise, fall, pol, miss, lead, trail;
    ctrl_t      ctrl;
    logic       tick;

    assign raw = {v_in, h_in};

    for (genvar k = 0; k < 2; k++) begin : g_chan
        localparam int TO = (k == 0) ? H_TIMEOUT : V_TIMEOUT;

        sync_input u_in (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw[k]),
            .s    (s[k]),
            .rise (rise[k]),
            .fall (fall[k])
        );

        sync_monitor #(.TIMEOUT(TO)) u_mon (
            .clk    (clk),
            .rst_n  (rst_n),
            .s      (s[k]),
            .rise   (rise[k]),
            .fall   (fall[k]),
            .pol    (pol[k]),
            .missing(miss[k])
        );

        assign lead[k]  = pol[k] ? fall[k] : rise[k];
        assign trail[k] = pol[k] ? rise[k] : fall[k];
    end

    assign h_out = s[0];
    assign v_out = s[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   ctrl <= '0;
        else if (reg_we && reg_addr)  ctrl <= ctrl_t'(reg_wdata[4:0]);
    end

    assign reg_rdata = reg_addr ? {3'b000, ctrl} : {4'b0000, miss, pol};

    clamp_gen #(.BASE(CLAMP_BASE)) u_clamp (
        .clk       (clk),
        .rst_n     (rst_n),
        .lead      (lead[0]),
        .trail     (trail[0]),
        .trail_sel (ctrl.trail_sel),
        .width_code(ctrl.width_code),
        .clamp     (clamp_out)
    );

    dummy_vgen #(.PERIOD(DUMMY_PERIOD)) u_dummy (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (ctrl.dummy_en),
        .tick (tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_event <= 1'b0;
        else        v_event <= lead[1] | (tick & ~ctrl.dummy_mute);
    end

    // R8: with the mute bit set, only a real leading edge may raise an event
    assert_mute_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.dummy_mute && !lead[1]) |=> !v_event);
    // R9: every vertical leading edge yields an event
    assert_edge_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lead[1] |=> v_event);
endmodule

// File: tb/sync_conditioner_bench.sv
module sync_conditioner_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       h_in, v_in;
    logic       reg_addr, reg_we;
    logic [7:0] reg_wdata, reg_rdata;
    logic       h_out, v_out, clamp_out, v_event;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_conditioner #(
        .CLK_HZ(3000), .FRAME_HZ(60), .H_TIMEOUT(512), .V_TIMEOUT(1024), .CLAMP_BASE(8)
    ) u_sync_conditioner (
        .clk(clk), .rst_n(rst_n), .h_in(h_in), .v_in(v_in),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .h_out(h_out), .v_out(v_out), .clamp_out(clamp_out), .v_event(v_event)
    );

    function automatic int width_of(input int code);
        return 8 << code;
    endfunction

    function automatic int pol_of(input int hi, input int lo);
        return (hi > lo) ? 1 : 0;
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_ctrl(input logic [7:0] val);
        @(negedge clk);
        reg_addr = 1'b1; reg_we = 1'b1; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 1'b0;
    endtask

    task automatic read_reg(input logic a, output int val);
        reg_addr = a;
        #1;
        val = int'(reg_rdata);
    endtask

    task automatic h_period(input int hi, input int lo);
        @(negedge clk); h_in = 1'b1; cyc(hi - 1);
        @(negedge clk); h_in = 1'b0; cyc(lo - 1);
    endtask

    task automatic v_period(input int hi, input int lo);
        @(negedge clk); v_in = 1'b1; cyc(hi - 1);
        @(negedge clk); v_in = 1'b0; cyc(lo - 1);
    endtask

    task automatic watch_clamp(input int n, output int first, output int cnt);
        first = 0; cnt = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (clamp_out) begin
                cnt++;
                if (first == 0) first = i;
            end
        end
    endtask

    task automatic count_events(input int n, output int cnt, output int first);
        cnt = 0; first = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (v_event) begin
                cnt++;
                if (first == 0) first = i;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: got 0 expected 1 (run completed)");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        int v, first, cnt, hi, lo, p, code, sel, d;
        int hist[0:63];
        void'($urandom(32'd7321));
        rst_n = 1'b0; h_in = 1'b0; v_in = 1'b0;
        reg_addr = 1'b0; reg_we = 1'b0; reg_wdata = '0;
        cyc(5);
        rst_n = 1'b1;

        // reset state (R10, R2, R3, R4)
        read_reg(1'b0, v); check("R10 status after reset", v, 0);
        read_reg(1'b1, v); check("R10 control after reset", v, 0);
        check("R5 clamp idle after reset", int'(clamp_out), 0);
        check("R9 no event after reset", int'(v_event), 0);

        // R1: two-clock pass-through with random data
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                check("R1 h_out delay", int'(h_out), hist[i-2] & 1);
                check("R1 v_out delay", int'(v_out), hist[i-2] >> 1);
            end
            hist[i] = int'($urandom % 4);
            h_in = hist[i][0];
            v_in = hist[i][1];
        end
        @(negedge clk); h_in = 1'b0; v_in = 1'b0; cyc(80);

        // R2: horizontal polarity from random duty, plus a tie
        for (int t = 0; t < 7; t++) begin
            hi = (t == 6) ? 20 : 5 + int'($urandom % 60);
            lo = (t == 6) ? 20 : 5 + int'($urandom % 60);
            repeat (3) h_period(hi, lo);
            @(negedge clk); h_in = 1'b1; cyc(6);
            read_reg(1'b0, v);
            check("R2 h polarity", v & 1, pol_of(hi, lo));
            @(negedge clk); h_in = 1'b0; cyc(10);
        end

        // R3: vertical polarity from random duty
        for (int t = 0; t < 5; t++) begin
            hi = 5 + int'($urandom % 80);
            lo = 5 + int'($urandom % 80);
            repeat (3) v_period(hi, lo);
            @(negedge clk); v_in = 1'b1; cyc(6);
            read_reg(1'b0, v);
            check("R3 v polarity", (v >> 1) & 1, pol_of(hi, lo));
            @(negedge clk); v_in = 1'b0; cyc(10);
        end

        // R5 / R6: clamp trigger edge and width, random settings and polarity
        for (int t = 0; t < 10; t++) begin
            p    = (t < 2) ? t : int'($urandom % 2);
            code = (t < 4) ? t : int'($urandom % 4);
            sel  = int'($urandom % 2);
            write_ctrl(8'((code << 1) | sel));
            if (p == 0) repeat (3) h_period(4, 150);
            else        repeat (3) h_period(150, 4);
            cyc(80);
            // rising edge: leading when positive, trailing when negative
            @(negedge clk); h_in = 1'b1;
            watch_clamp(100, first, cnt);
            d = ((p == 0) == (sel == 0)) ? 1 : 0;
            check("R5 clamp start on rising edge", first, d ? 3 : 0);
            check("R6 clamp width on rising edge", cnt, d ? width_of(code) : 0);
            @(negedge clk); h_in = 1'b0;
            watch_clamp(160, first, cnt);
            check("R5 clamp start on falling edge", first, d ? 0 : 3);
            check("R6 clamp width on falling edge", cnt, d ? 0 : width_of(code));
        end
        write_ctrl(8'h00);

        // R4: missing detection and clearing
        cyc(1100);
        read_reg(1'b0, v);
        check("R4 h missing set", (v >> 2) & 1, 1);
        check("R4 v missing set", (v >> 3) & 1, 1);
        @(negedge clk); h_in = 1'b1; cyc(5);
        read_reg(1'b0, v);
        check("R4 h missing cleared", (v >> 2) & 1, 0);
        check("R4 v missing still set", (v >> 3) & 1, 1);
        @(negedge clk); v_in = 1'b1; cyc(5);
        read_reg(1'b0, v);
        check("R4 v missing cleared", (v >> 3) & 1, 0);
        @(negedge clk); h_in = 1'b0; v_in = 1'b0; cyc(20);

        // establish positive vertical polarity
        repeat (3) v_period(5, 40);
        cyc(20);

        // R7: dummy rate
        write_ctrl(8'h08);
        count_events(500, cnt, first);
        check("R7 dummy events per 500 clocks", cnt, 10);

        // R8: mute keeps ticks off, real edges still pass
        write_ctrl(8'h18);
        count_events(200, cnt, first);
        check("R8 muted dummy events", cnt, 0);
        @(negedge clk); v_in = 1'b1;
        count_events(60, cnt, first);
        check("R8 real edge count while muted", cnt, 1);
        check("R8 real edge timing while muted", first, 3);
        @(negedge clk); v_in = 1'b0; cyc(200);

        // R9: leading edge landing on a dummy tick
        write_ctrl(8'h08);
        do @(negedge clk); while (!v_event);
        cyc(47);
        v_in = 1'b1;
        count_events(13, cnt, first);
        check("R9 coincident events merge", cnt, 1);
        check("R9 coincident event position", first, 3);
        cyc(10);
        @(negedge clk); v_in = 1'b0; cyc(200);

        // R9: leading edge away from a tick
        do @(negedge clk); while (!v_event);
        cyc(17);
        v_in = 1'b1;
        count_events(33, cnt, first);
        check("R9 separate events", cnt, 2);
        check("R9 edge event position", first, 3);
        @(negedge clk); v_in = 1'b0; cyc(20);

        // R10: control readback masks unused bits
        write_ctrl(8'hFF);
        read_reg(1'b1, v);
        check("R10 control readback", v, 8'h1F);
        write_ctrl(8'h00);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule